// File: doc/BRIEF.md
# External Memory Chip-Select Decoder with Address Extension

This block turns a 32-bit bus address into four active-low chip selects for external memory devices. Each select owns a 16 MB slot in a contiguous 64 MB region that starts at 0x10000000. An address outside that region, or a cycle with no valid bus access, leaves every select high.

A byte-wide configuration register controls two features. First, the selects in slot 1 and slot 3 each have an extend bit. When an extend bit is set, the slot-0 select also covers that slot, so its window grows to 32 MB. The extended slot's own pin keeps going low only inside its own slot. Seen from the memory, that pin therefore behaves as an inverted 25th address line. A 256 Mb device can then sit behind the slot-0 select with an external inverter, and no extra pin is needed.

Second, every select has a route bit. The route bit sends the select either to the primary bus pins or to the secondary bus pins. The pin on the bus that was not chosen stays high.

Top module: `memsel_decoder`

## Requirements
- R1: After reset the configuration register reads 0x00, both extend bits are clear and every select is routed to the primary bus.
- R2: While bus_valid is low, all eight chip-select outputs are high.
- R3: A valid address whose bits [31:24] lie outside 0x10..0x13 drives all eight outputs high.
- R4: With both extend bits clear, select k (k = 0..3) is low only for addresses 0x1k000000..0x1kFFFFFF.
- R5: With configuration bit 0 set (extend slot 1), select 0 is low for 0x10000000..0x11FFFFFF and select 1 is low only for 0x11000000..0x11FFFFFF.
- R6: With configuration bit 1 set (extend slot 3), select 0 is low for 0x10xxxxxx and 0x13xxxxxx, and not for 0x11xxxxxx or 0x12xxxxxx. Select 3 is low only for 0x13xxxxxx.
- R7: Slots 0 and 2 have no extend control. Configuration bits 2 and 3 are reserved: writes to them are dropped, they read 0 and they do not change decoding.
- R8: Configuration bit 4+k routes select k: 0 drives cs_pri_n[k] and 1 drives cs_sec_n[k]. The pin of select k on the other bus stays high.
- R9: A write with cfg_we high and cfg_addr = 0 takes effect at the next rising clock edge and is then visible on cfg_rdata (cfg_addr = 0). Writes to any other cfg_addr are ignored, and reads of them return 0.
- R10: With both extend bits set, select 0 covers 0x10, 0x11 and 0x13 slots, while select 2 keeps only 0x12xxxxxx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| bus_valid | input | 1 | A bus cycle is active |
| bus_addr | input | 32 | Bus byte address |
| cs_pri_n | output | 4 | Active-low selects on the primary bus |
| cs_sec_n | output | 4 | Active-low selects on the secondary bus |

## Verification
Some properties are checked on every cycle. Idle and out-of-region outputs stay high. No select is ever low on both buses at once. Select 0, select 2 and select 3 are never low outside the slots their extend state allows. Reserved bits always read zero. A register write always shows up one edge later.

Other behaviour can only be shown by the bench scenarios. These cover the exact reset value and the exact output pattern for each extend and route combination. They also cover slot boundaries, the cycle before a write lands, and writes to offsets that do not exist.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
   localparam int CS_COUNT      = 4;
   localparam int CFG_EXT1_BIT  = 0;
   localparam int CFG_EXT3_BIT  = 1;
   localparam int CFG_ROUTE_LSB = 4;
   localparam int CFG_MIN_W     = CFG_ROUTE_LSB + CS_COUNT;
   // slots that may fold into slot 0
   localparam logic [CS_COUNT-1:0] EXT_CAPABLE = 4'b1010;
   // bits that hold state; the rest are reserved and read 0
   localparam logic [7:0] CFG_WR_MASK = 8'hF3;
endpackage

// File: rtl/memsel_cfg_reg.sv
module memsel_cfg_reg
   import memsel_pkg::*;
#(
   parameter int              DW     = 8,
   parameter int              AW     = 2,
   parameter logic [AW-1:0]   OFFSET = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [AW-1:0]       addr,
   input  logic [DW-1:0]       wdata,
   output logic [DW-1:0]       rdata,
   output logic [CS_COUNT-1:0] ext_en,
   output logic [CS_COUNT-1:0] route_sec
);
   localparam logic [DW-1:0] WMASK = DW'(CFG_WR_MASK);

   if (DW < CFG_MIN_W) begin : g_bad_dw
      $error("memsel_cfg_reg: DW too small for route field");
   end

   logic [DW-1:0] cfg_q;
   logic          hit;

   assign hit = (addr == OFFSET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (we && hit)
         cfg_q <= wdata & WMASK;
   end

   assign rdata = hit ? cfg_q : '0;

   for (genvar i = 0; i < CS_COUNT; i++) begin : g_fields
      if (EXT_CAPABLE[i] && i == 1) begin : g_ext1
         assign ext_en[i] = cfg_q[CFG_EXT1_BIT];
      end else if (EXT_CAPABLE[i] && i == 3) begin : g_ext3
         assign ext_en[i] = cfg_q[CFG_EXT3_BIT];
      end else begin : g_noext
         assign ext_en[i] = 1'b0;
      end
      assign route_sec[i] = cfg_q[CFG_ROUTE_LSB+i];
   end
endmodule

// File: rtl/memsel_window_match.sv
module memsel_window_match
   import memsel_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SLOT_LSB  = 24,
   parameter int BASE_SLOT = 16
) (
   input  logic                valid,
   input  logic [ADDR_W-1:0]   addr,
   output logic [CS_COUNT-1:0] hit
);
   localparam int SLOT_W = ADDR_W - SLOT_LSB;

   if (SLOT_LSB < 1 || SLOT_LSB >= ADDR_W) begin : g_bad_lsb
      $error("memsel_window_match: SLOT_LSB out of range");
   end
   if (SLOT_W < 31 && (BASE_SLOT + CS_COUNT) > (1 << SLOT_W)) begin : g_bad_base
      $error("memsel_window_match: region does not fit address space");
   end

   logic [ADDR_W-1:0] slot_full;
   assign slot_full = addr >> SLOT_LSB;

   for (genvar i = 0; i < CS_COUNT; i++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ID = ADDR_W'(BASE_SLOT + i);
      assign hit[i] = valid && (slot_full == SLOT_ID);
   end
endmodule

// File: rtl/memsel_cs_merge.sv
module memsel_cs_merge
   import memsel_pkg::*;
(
   input  logic [CS_COUNT-1:0] hit,
   input  logic [CS_COUNT-1:0] ext_en,
   output logic [CS_COUNT-1:0] sel
);
   logic [CS_COUNT-1:0] folded;
   assign folded = hit & ext_en & EXT_CAPABLE;

   for (genvar i = 0; i < CS_COUNT; i++) begin : g_sel
      if (i == 0) begin : g_base
         assign sel[i] = hit[i] | (|folded);
      end else begin : g_own
         assign sel[i] = hit[i];
      end
   end
endmodule

// File: rtl/memsel_bus_route.sv
module memsel_bus_route
   import memsel_pkg::*;
(
   input  logic [CS_COUNT-1:0] sel,
   input  logic [CS_COUNT-1:0] route_sec,
   output logic [CS_COUNT-1:0] pri_n,
   output logic [CS_COUNT-1:0] sec_n
);
   for (genvar i = 0; i < CS_COUNT; i++) begin : g_pin
      assign pri_n[i] = ~(sel[i] & ~route_sec[i]);
      assign sec_n[i] = ~(sel[i] &  route_sec[i]);
   end
endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
   import memsel_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SLOT_LSB   = 24,
   parameter int BASE_SLOT  = 16,
   parameter int CFG_DW     = 8,
   parameter int CFG_AW     = 2,
   parameter int CFG_OFFSET = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CFG_AW-1:0]   cfg_addr,
   input  logic [CFG_DW-1:0]   cfg_wdata,
   output logic [CFG_DW-1:0]   cfg_rdata,
   input  logic                bus_valid,
   input  logic [ADDR_W-1:0]   bus_addr,
   output logic [CS_COUNT-1:0] cs_pri_n,
   output logic [CS_COUNT-1:0] cs_sec_n
);
   if (CFG_OFFSET < 0 || CFG_OFFSET >= (1 << CFG_AW)) begin : g_bad_off
      $error("memsel_decoder: CFG_OFFSET outside register space");
   end

   logic [CS_COUNT-1:0] ext_en;
   logic [CS_COUNT-1:0] route_sec;
   logic [CS_COUNT-1:0] hit;
   logic [CS_COUNT-1:0] sel;

   memsel_cfg_reg #(
      .DW(CFG_DW), .AW(CFG_AW), .OFFSET(CFG_AW'(CFG_OFFSET))
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata),
      .ext_en(ext_en), .route_sec(route_sec)
   );

   memsel_window_match #(
      .ADDR_W(ADDR_W), .SLOT_LSB(SLOT_LSB), .BASE_SLOT(BASE_SLOT)
   ) u_match (
      .valid(bus_valid), .addr(bus_addr), .hit(hit)
   );

   memsel_cs_merge u_merge (
      .hit(hit), .ext_en(ext_en), .sel(sel)
   );

   memsel_bus_route u_route (
      .sel(sel), .route_sec(route_sec),
      .pri_n(cs_pri_n), .sec_n(cs_sec_n)
   );
endmodule

// File: rtl/memsel_decoder_chk.sv
module memsel_decoder_chk
   import memsel_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SLOT_LSB   = 24,
   parameter int BASE_SLOT  = 16,
   parameter int CFG_DW     = 8,
   parameter int CFG_AW     = 2,
   parameter int CFG_OFFSET = 0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_we,
   input logic [CFG_AW-1:0]   cfg_addr,
   input logic [CFG_DW-1:0]   cfg_wdata,
   input logic [CFG_DW-1:0]   cfg_rdata,
   input logic                bus_valid,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [CS_COUNT-1:0] cs_pri_n,
   input logic [CS_COUNT-1:0] cs_sec_n
);
   localparam logic [CFG_AW-1:0] OFF   = CFG_AW'(CFG_OFFSET);
   localparam logic [CFG_DW-1:0] WMASK = CFG_DW'(CFG_WR_MASK);

   logic [ADDR_W-1:0]   slot;
   logic [CS_COUNT-1:0] low;
   logic                in_region;

   assign slot      = bus_addr >> SLOT_LSB;
   assign low       = ~cs_pri_n | ~cs_sec_n;
   assign in_region = (slot >= ADDR_W'(BASE_SLOT)) &&
                      (slot <  ADDR_W'(BASE_SLOT + CS_COUNT));

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |-> (&cs_pri_n && &cs_sec_n));   // R2

   AST_OUTSIDE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !in_region |-> (&cs_pri_n && &cs_sec_n));   // R3

   AST_ONE_BUS_PER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      ((~cs_pri_n & ~cs_sec_n) == '0));            // R8

   AST_CS2_OWN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      low[2] |-> (slot == ADDR_W'(BASE_SLOT + 2))); // R4

   AST_CS3_OWN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      low[3] |-> (slot == ADDR_W'(BASE_SLOT + 3))); // R6

   AST_CS0_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (low[0] && cfg_addr == OFF) |->
         ((slot == ADDR_W'(BASE_SLOT)) ||
          (slot == ADDR_W'(BASE_SLOT + 1) && cfg_rdata[CFG_EXT1_BIT]) ||
          (slot == ADDR_W'(BASE_SLOT + 3) && cfg_rdata[CFG_EXT3_BIT]))); // R5

   AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_rdata & ~WMASK) == '0));               // R7

   AST_WRITE_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == OFF) |=>
         (cfg_addr != OFF || cfg_rdata == ($past(cfg_wdata) & WMASK))); // R9
endmodule

bind memsel_decoder memsel_decoder_chk #(
   .ADDR_W(ADDR_W), .SLOT_LSB(SLOT_LSB), .BASE_SLOT(BASE_SLOT),
   .CFG_DW(CFG_DW), .CFG_AW(CFG_AW), .CFG_OFFSET(CFG_OFFSET)
) u_chk (.*);

// File: tb/tb_memsel_decoder.sv
module tb_memsel_decoder;
   typedef struct packed {
      logic [7:0]  cfg;
      logic        valid;
      logic [31:0] addr;
      logic [3:0]  pri;
      logic [3:0]  sec;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 30;
   // R2 idle, R3 outside, R4 default, R5 ext1, R6 ext3, R7 reserved, R8 route, R10 both
   localparam vec_t VEC [NV] = '{
      '{8'h00, 1'b1, 32'h10000000, 4'b1110, 4'b1111, 4'd4},
      '{8'h00, 1'b1, 32'h10FFFFFF, 4'b1110, 4'b1111, 4'd4},
      '{8'h00, 1'b1, 32'h11000000, 4'b1101, 4'b1111, 4'd4},
      '{8'h00, 1'b1, 32'h12345678, 4'b1011, 4'b1111, 4'd4},
      '{8'h00, 1'b1, 32'h13FFFFFF, 4'b0111, 4'b1111, 4'd4},
      '{8'h00, 1'b1, 32'h0FFFFFFF, 4'b1111, 4'b1111, 4'd3},
      '{8'h00, 1'b1, 32'h14000000, 4'b1111, 4'b1111, 4'd3},
      '{8'h00, 1'b1, 32'hFFFFFFFF, 4'b1111, 4'b1111, 4'd3},
      '{8'h00, 1'b0, 32'h10000000, 4'b1111, 4'b1111, 4'd2},
      '{8'h01, 1'b1, 32'h10800000, 4'b1110, 4'b1111, 4'd5},
      '{8'h01, 1'b1, 32'h11000000, 4'b1100, 4'b1111, 4'd5},
      '{8'h01, 1'b1, 32'h11FFFFFF, 4'b1100, 4'b1111, 4'd5},
      '{8'h01, 1'b1, 32'h12000000, 4'b1011, 4'b1111, 4'd5},
      '{8'h01, 1'b1, 32'h13000000, 4'b0111, 4'b1111, 4'd5},
      '{8'h02, 1'b1, 32'h10000000, 4'b1110, 4'b1111, 4'd6},
      '{8'h02, 1'b1, 32'h11000000, 4'b1101, 4'b1111, 4'd6},
      '{8'h02, 1'b1, 32'h12000000, 4'b1011, 4'b1111, 4'd6},
      '{8'h02, 1'b1, 32'h13ABCDEF, 4'b0110, 4'b1111, 4'd6},
      '{8'h03, 1'b1, 32'h10000000, 4'b1110, 4'b1111, 4'd10},
      '{8'h03, 1'b1, 32'h11000000, 4'b1100, 4'b1111, 4'd10},
      '{8'h03, 1'b1, 32'h12000000, 4'b1011, 4'b1111, 4'd10},
      '{8'h03, 1'b1, 32'h13000000, 4'b0110, 4'b1111, 4'd10},
      '{8'h21, 1'b1, 32'h11000000, 4'b1110, 4'b1101, 4'd8},
      '{8'h21, 1'b1, 32'h10000000, 4'b1110, 4'b1111, 4'd8},
      '{8'hF3, 1'b1, 32'h13000000, 4'b1111, 4'b0110, 4'd8},
      '{8'hF3, 1'b0, 32'h13000000, 4'b1111, 4'b1111, 4'd2},
      '{8'h50, 1'b1, 32'h12000000, 4'b1111, 4'b1011, 4'd8},
      '{8'hF3, 1'b1, 32'h20000000, 4'b1111, 4'b1111, 4'd3},
      '{8'h0C, 1'b1, 32'h11000000, 4'b1101, 4'b1111, 4'd7},
      '{8'h0C, 1'b1, 32'h13000000, 4'b0111, 4'b1111, 4'd7}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [7:0]  cfg_wdata = 8'h00;
   logic [7:0]  cfg_rdata;
   logic        bus_valid = 1'b0;
   logic [31:0] bus_addr = 32'h0;
   logic [3:0]  cs_pri_n;
   logic [3:0]  cs_sec_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   memsel_decoder dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_valid(bus_valid),
      .bus_addr(bus_addr), .cs_pri_n(cs_pri_n), .cs_sec_n(cs_sec_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_addr = 2'd0;
   endtask

   task automatic drive_bus(input logic v, input logic [31:0] a);
      bus_valid = v; bus_addr = a;
      #1;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1: reset values
      check("R1 rdata in reset", {24'h0, cfg_rdata}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      drive_bus(1'b1, 32'h11000000);
      check("R1 ext clear, primary route", {24'h0, cs_sec_n, cs_pri_n}, {24'h0, 4'b1111, 4'b1101});
      drive_bus(1'b1, 32'h13000000);
      check("R1 ext3 clear", {28'h0, cs_pri_n}, {28'h0, 4'b0111});

      // table walk
      for (int i = 0; i < NV; i++) begin
         write_cfg(2'd0, VEC[i].cfg);
         drive_bus(VEC[i].valid, VEC[i].addr);
         check($sformatf("R%0d vec %0d primary", VEC[i].req, i), {28'h0, cs_pri_n}, {28'h0, VEC[i].pri});
         check($sformatf("R%0d vec %0d secondary", VEC[i].req, i), {28'h0, cs_sec_n}, {28'h0, VEC[i].sec});
         check($sformatf("R9 vec %0d readback", i), {24'h0, cfg_rdata}, {24'h0, VEC[i].cfg & 8'hF3});
      end

      // R9: write lands at the next edge, not before
      write_cfg(2'd0, 8'h00);
      drive_bus(1'b1, 32'h11000000);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'h01;
      #1;
      check("R9 before edge", {28'h0, cs_pri_n}, {28'h0, 4'b1101});
      @(negedge clk);
      cfg_we = 1'b0;
      #1;
      check("R9 after edge", {28'h0, cs_pri_n}, {28'h0, 4'b1100});

      // R9: other offsets ignored and read zero
      write_cfg(2'd1, 8'h02);
      write_cfg(2'd3, 8'hFF);
      cfg_addr = 2'd1;
      #1;
      check("R9 other offset reads zero", {24'h0, cfg_rdata}, 32'h0);
      cfg_addr = 2'd0;
      #1;
      check("R9 offset 0 unchanged", {24'h0, cfg_rdata}, 32'h01);
      drive_bus(1'b1, 32'h13000000);
      check("R9 ignored write no decode effect", {24'h0, cs_sec_n, cs_pri_n}, {24'h0, 4'b1111, 4'b0111});

      // R7: reserved-only write keeps decoding default
      write_cfg(2'd0, 8'h04);
      drive_bus(1'b1, 32'h12000000);
      check("R7 reserved bit no effect", {24'h0, cs_sec_n, cs_pri_n}, {24'h0, 4'b1111, 4'b1011});
      check("R7 reserved reads zero", {24'h0, cfg_rdata}, 32'h0);

      // R1: reset mid-run clears the register
      write_cfg(2'd0, 8'hF3);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 async reset clears", {24'h0, cfg_rdata}, 32'h0);
      drive_bus(1'b1, 32'h11000000);
      check("R1 reset restores primary default", {24'h0, cs_sec_n, cs_pri_n}, {24'h0, 4'b1111, 4'b1101});
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end
endmodule